// File: doc/BRIEF.md
# Gated clock frequency meter

This block measures the frequency of one clock, chosen out of a bank of up to 32 inputs, against a reference clock. Software writes a control word that holds the following fields:

- the gate length, in microseconds;
- the input select;
- a measured-path enable;
- continuous mode;
- interrupt enable;
- the start bit.

The block then opens a gate window timed by a microsecond tick, which comes from a prescaler on the reference clock. While the window is open, it counts rising edges of the selected clock. When the window closes, it hands the final count back to the reference domain.

The gate level crosses into the measured domain through a two-flop synchroniser. The counter runs in the measured domain and holds its value once the gate falls. A toggle is then passed back to the reference side, and on that toggle the held count is captured into the result.

A busy flag reads 1 from the start of a measurement until the result is valid. In continuous mode the block starts a new window after each result, for as long as the start bit stays set. An optional level interrupt flags each new result.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, busy (read bit 31) is 0, the result is 0 and irq is 0.
- R2: With gate field N (bits [15:0]), the gate stays open for N+1 ticks of TICK_DIV reference cycles each. The result equals the number of selected-clock rising edges in that window, within ±2 counts. N=0 gives a one-tick window.
- R3: The select field at bits [24:20] chooses which meas_clk bit is counted. Inputs with different frequencies give correspondingly different results.
- R4: A write with bit 16 set while idle starts a measurement, and busy reads 1 on the cycle after the write. Busy drops to 0 in the same cycle that the new result appears. A write with bit 16 set while busy starts nothing.
- R5: In single-shot mode (bit 17 clear), the block stays idle after a result and the result holds until the next start write.
- R6: With bit 17 and bit 16 both set, each result is followed at once by a new window, and busy stays 1.
- R7: Clearing bit 16 while in continuous mode lets the current window finish and deliver its result; busy then stays 0.
- R8: With bit 18 set, irq goes to 1 when a result is captured, and any control write clears it. With bit 18 clear, irq never rises, and irq is never 1 while bit 18 reads 0.
- R9: The edge count saturates at 65535 and does not wrap.
- R10: With bit 19 clear, no edges are counted and the result is 0.
- R11: Read bits [24:0] return the last written control bits, and bits [30:25] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_clk | input | NCLK | Bank of clocks to be measured |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word |
| ctrl_rdata | output | 32 | Control readback with busy in bit 31 |
| result | output | RES_W | Edge count of the last window |
| irq | output | 1 | Level interrupt, result ready |

## Verification
A table of select and gate pairs runs four clocks of unrelated periods through short, medium and single-tick windows. Because each clock has its own count, a wrong input mux shows up separately from a wrong window length. Further tests cover the following:

- a window long enough to drive the fastest clock past the counter range, which separates saturation from wrap-around;
- a run with the path disabled, which must read zero;
- a continuous run stopped part-way, which shows re-arming and a clean stop;
- single-shot runs with and without interrupt enable, which check that irq is gated and that a write clears it.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int WORD_W  = 32;
  localparam int GATE_W  = 16;
  localparam int SEL_W   = 5;
  localparam int B_START = 16;
  localparam int B_CONT  = 17;
  localparam int B_IRQEN = 18;
  localparam int B_PATH  = 19;
  localparam int B_SEL   = 20;
  localparam int B_BUSY  = 31;
  localparam int CTRL_W  = B_SEL + SEL_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GATE  = 2'd1,
    ST_DRAIN = 2'd2
  } gate_state_e;
endpackage

// File: rtl/cfm_tick.sv
module cfm_tick #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    tick = (pcnt_q == LAST);
    if (clr || tick) pcnt_d = '0;
    else             pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/cfm_edge_counter.sv
module cfm_edge_counter #(
  parameter int NCLK  = 32,
  parameter int SEL_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             rst_n,
  input  logic [NCLK-1:0]  meas_clk,
  input  logic [SEL_W-1:0] sel,
  input  logic             path_en,
  input  logic             gate,
  output logic             done_tgl,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic mclk;
  logic g1_q, g2_q, g3_q;
  logic tgl_q, tgl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mclk = 1'b0;
    for (int i = 0; i < NCLK; i++)
      if (sel == i[SEL_W-1:0]) mclk = meas_clk[i];
  end

  always_comb begin
    cnt_d = cnt_q;
    tgl_d = tgl_q;
    if (g2_q && !g3_q)
      cnt_d = {{(CNT_W-1){1'b0}}, path_en};
    else if (g2_q && path_en && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + 1'b1;
    if (g3_q && !g2_q)
      tgl_d = ~tgl_q;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q  <= 1'b0;
      g2_q  <= 1'b0;
      g3_q  <= 1'b0;
      tgl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      g1_q  <= gate;
      g2_q  <= g1_q;
      g3_q  <= g2_q;
      tgl_q <= tgl_d;
      cnt_q <= cnt_d;
    end
  end

  assign done_tgl = tgl_q;
  assign count    = cnt_q;
endmodule

// File: rtl/cfm_gate_ctrl.sv
module cfm_gate_ctrl
  import cfm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RES_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              arm,
  input  logic              rearm,
  input  logic [GATE_W-1:0] gate_len,
  input  logic              done_tgl,
  input  logic [CNT_W-1:0]  count,
  output logic              gate,
  output logic              busy,
  output logic              load,
  output logic              capture,
  output logic [RES_W-1:0]  result
);
  gate_state_e st_q, st_d;
  logic [GATE_W-1:0] rem_q, rem_d;
  logic t1_q, t2_q, t3_q;
  logic [RES_W-1:0] res_q, res_d;
  logic tgl_edge;

  assign tgl_edge = t2_q ^ t3_q;

  always_comb begin
    st_d    = st_q;
    rem_d   = rem_q;
    res_d   = res_q;
    load    = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: if (arm) begin
        st_d  = ST_GATE;
        rem_d = gate_len;
        load  = 1'b1;
      end
      ST_GATE: if (tick) begin
        if (rem_q == '0) st_d = ST_DRAIN;
        else             rem_d = rem_q - 1'b1;
      end
      ST_DRAIN: if (tgl_edge) begin
        capture = 1'b1;
        res_d   = RES_W'(count);
        if (rearm) begin
          st_d  = ST_GATE;
          rem_d = gate_len;
          load  = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      res_q <= '0;
      t1_q  <= 1'b0;
      t2_q  <= 1'b0;
      t3_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      res_q <= res_d;
      t1_q  <= done_tgl;
      t2_q  <= t1_q;
      t3_q  <= t2_q;
    end
  end

  assign gate   = (st_q == ST_GATE);
  assign busy   = (st_q != ST_IDLE);
  assign result = res_q;
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
  import cfm_pkg::*;
#(
  parameter int NCLK     = 32,
  parameter int TICK_DIV = 200,
  parameter int CNT_W    = 16,
  parameter int RES_W    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLK-1:0]   meas_clk,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ctrl_rdata,
  output logic [RES_W-1:0]  result,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic irq_q, irq_d;
  logic busy, arm, rearm, load, capture, tick, gate, done_tgl;
  logic [GATE_W-1:0] gate_len;
  logic [CNT_W-1:0] count;

  always_comb begin
    ctrl_d   = wr_en ? wr_data[CTRL_W-1:0] : ctrl_q;
    arm      = wr_en && wr_data[B_START];
    rearm    = ctrl_q[B_START] && ctrl_q[B_CONT];
    gate_len = arm ? wr_data[GATE_W-1:0] : ctrl_q[GATE_W-1:0];
    irq_d    = (capture && ctrl_d[B_IRQEN]) || (irq_q && !wr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= irq_d;
    end
  end

  cfm_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(load), .tick(tick)
  );

  cfm_gate_ctrl #(.CNT_W(CNT_W), .RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .rearm(rearm),
    .gate_len(gate_len), .done_tgl(done_tgl), .count(count),
    .gate(gate), .busy(busy), .load(load), .capture(capture), .result(result)
  );

  cfm_edge_counter #(.NCLK(NCLK), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .rst_n(rst_n), .meas_clk(meas_clk), .sel(ctrl_q[B_SEL +: SEL_W]),
    .path_en(ctrl_q[B_PATH]), .gate(gate), .done_tgl(done_tgl), .count(count)
  );

  assign ctrl_rdata = {busy, {(B_BUSY-CTRL_W){1'b0}}, ctrl_q};
  assign irq        = irq_q;
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
  parameter int RES_W = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rdata,
  input logic [RES_W-1:0] result,
  input logic        irq
);
  // R4: a start write while idle makes busy read 1 next cycle
  p_busy_on_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[16] && !rdata[31]) |=> rdata[31]);

  // R5: idle stays idle without a write
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdata[31] && !wr_en) |=> !rdata[31]);

  // R5: result holds while idle
  p_result_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdata[31] && $past(!rdata[31])) |-> $stable(result));

  // R8: irq only while interrupt enable reads 1
  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rdata[18]);

  // R8: a write clears a pending irq unless a new result lands together with it
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && irq && !wr_data[18]) |=> !irq);
endmodule

bind clk_freq_meter cfm_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rdata(ctrl_rdata), .result(result), .irq(irq)
);

// File: tb/clk_freq_meter_bench.sv
`timescale 1ns/1ps
module clk_freq_meter_bench;
  localparam int NCLK = 4;
  localparam int TDIV = 10;
  localparam int RW   = 20;
  localparam int NVEC = 6;
  // each entry: {sel[4:0], gate[15:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {5'd0, 16'd9}, {5'd1, 16'd9}, {5'd2, 16'd4},
    {5'd3, 16'd19}, {5'd0, 16'd0}, {5'd2, 16'd99}
  };

  logic clk, rst_n, wr_en, irq;
  logic [NCLK-1:0] mclk;
  logic [31:0] wr_data, rdata;
  logic [RW-1:0] result;
  int checks, fails;
  int cyc;

  clk_freq_meter #(.NCLK(NCLK), .TICK_DIV(TDIV), .CNT_W(16), .RES_W(RW)) u_clk_freq_meter (
    .clk(clk), .rst_n(rst_n), .meas_clk(mclk), .wr_en(wr_en),
    .wr_data(wr_data), .ctrl_rdata(rdata), .result(result), .irq(irq)
  );

  initial begin clk = 0; forever #2.5 clk = ~clk; end
  initial begin mclk = '0; end
  always #3.5 mclk[0] = ~mclk[0];
  always #6.5 mclk[1] = ~mclk[1];
  always #1.5 mclk[2] = ~mclk[2];
  always #1.0 mclk[3] = ~mclk[3];

  function automatic int period_ps(input int s);
    case (s)
      0: return 7000;
      1: return 13000;
      2: return 3000;
      default: return 2000;
    endcase
  endfunction

  function automatic int expect_cnt(input int s, input int g);
    int e;
    e = ((g + 1) * TDIV * 5000) / period_ps(s);
    if (e > 65535) e = 65535;
    return e;
  endfunction

  function automatic logic [31:0] mk(input int s, input int g, input bit st,
                                     input bit co, input bit ie, input bit pe);
    return {7'd0, s[4:0], pe, ie, co, st, g[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && rdata[31]; i++) @(negedge clk);
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim && !irq; i++) @(negedge clk);
  endtask

  task automatic near(input int act, input int exp_v, input string tag);
    chk((act >= exp_v - 2) && (act <= exp_v + 2), tag, act, exp_v);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int e;
    logic [RW-1:0] held;
    checks = 0; fails = 0; cyc = 0;
    rst_n = 0; wr_en = 0; wr_data = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rdata[31] == 1'b0, "R1 busy", rdata[31], 0);
    chk(result == '0, "R1 result", result, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 table walk
    for (int v = 0; v < NVEC; v++) begin
      int s, g;
      s = int'(VEC[v][20:16]); g = int'(VEC[v][15:0]);
      wr(mk(s, g, 1, 0, 0, 1));
      chk(rdata[31] == 1'b1, "R4 busy after start", rdata[31], 1);
      wait_idle(40000);
      e = expect_cnt(s, g);
      near(int'(result), e, $sformatf("R2 R3 vec%0d", v));
    end

    // R11 readback
    wr(mk(1, 77, 0, 0, 1, 0));
    chk(rdata[30:0] == mk(1, 77, 0, 0, 1, 0) & 32'h01FF_FFFF, "R11 readback",
        int'(rdata[30:0]), int'(mk(1, 77, 0, 0, 1, 0)));
    chk(rdata[31] == 1'b0, "R4 no start without bit16", rdata[31], 0);

    // R9 saturation
    wr(mk(3, 3000, 1, 0, 0, 1));
    wait_idle(40000);
    chk(result == 20'd65535, "R9 saturate", result, 65535);

    // R10 path disabled
    wr(mk(3, 9, 1, 0, 0, 0));
    wait_idle(40000);
    chk(result == '0, "R10 path off", result, 0);

    // R4 start ignored while busy, R5 one-shot hold, R8 irq off
    wr(mk(0, 49, 1, 0, 0, 1));
    repeat (20) @(negedge clk);
    wr(mk(0, 0, 1, 0, 0, 1));
    wait_idle(40000);
    near(int'(result), expect_cnt(0, 49), "R4 restart ignored while busy");
    held = result;
    repeat (400) @(negedge clk);
    chk(rdata[31] == 1'b0, "R5 stays idle", rdata[31], 0);
    chk(result == held, "R5 result held", result, held);
    chk(irq == 1'b0, "R8 irq disabled", irq, 0);

    // R8 irq enabled single-shot, cleared by write
    wr(mk(2, 9, 1, 0, 1, 1));
    wait_idle(40000);
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq set", irq, 1);
    wr(mk(2, 9, 0, 0, 1, 1));
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);

    // R6 continuous, R7 stop after current window
    wr(mk(0, 19, 1, 1, 1, 1));
    wait_irq(40000);
    chk(irq == 1'b1, "R6 first result irq", irq, 1);
    chk(rdata[31] == 1'b1, "R6 rearmed busy", rdata[31], 1);
    near(int'(result), expect_cnt(0, 19), "R6 continuous count");
    wr(mk(0, 19, 0, 1, 1, 1));
    chk(rdata[31] == 1'b1, "R7 window continues", rdata[31], 1);
    wait_idle(40000);
    @(negedge clk);
    chk(irq == 1'b1, "R7 final result irq", irq, 1);
    near(int'(result), expect_cnt(0, 19), "R7 final count");
    repeat (600) @(negedge clk);
    chk(rdata[31] == 1'b0, "R7 stopped", rdata[31], 0);

    // R1 reset mid-measurement
    wr(mk(1, 200, 1, 0, 1, 1));
    rst_n = 0;
    @(negedge clk);
    chk(rdata[31] == 1'b0 && result == '0 && irq == 1'b0, "R1 reset mid-run",
        int'(rdata[31]), 0);
    rst_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule